// File: doc/BRIEF.md
# Six-pin GPIO port with shared serial pins

This block is a general-purpose I/O port of six pins that sits on a byte-wide register bus. Software reaches three registers: an output value latch, a per-pin driver enable (direction) and a per-pin pullup enable. For each pin the port produces a driver enable, a driven value and a pullup request. It also takes the raw level seen at the pin. Pin levels pass through a two-stage synchronizer before anything inside the block uses them.

Two of the pins can be lent to a UART-style serial peripheral. While the serial enable input is high, pin 0 drives the peripheral's transmit signal and pin 1 returns the synchronized pin level to the peripheral as receive data. The direction bits for those two pins then have no effect on the pins. The read path still follows the direction bits, so software sees either the latch or the pin on each bit. The output latches have no reset and keep their contents across a reset pulse.

Top module: `gpio_shared_port`

## Requirements
- R1: Register select `addr` 0 is the data latch, 1 the direction register, 2 the pullup register, and 3 reads as zero. Bits 7 and 6 of every read are 0, and so are bits written as 1 there.
- R2: A register changes only at a rising clock edge with `wr_en` high and its address selected. After reset, direction and pullup both read 0x00, and all `pin_oe` and `pin_pu` outputs are 0.
- R3: With `ser_en` low, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals data latch bit i, for all six pins.
- R4: With `ser_en` high, `pin_oe[0]` is 1 and `pin_out[0]` equals `ser_tx`, and `pin_oe[1]` is 0, whatever the direction bits 0 and 1 hold. Pins 5..2 still follow R3.
- R5: `ser_rx` equals the synchronized level of pin 1 while `ser_en` is high, and is 1 (line idle) while `ser_en` is low.
- R6: A read at address 0 returns, per bit, the latch when its direction bit is 1 and the synchronized pin level when it is 0. This holds also for pins 0 and 1 while `ser_en` is high.
- R7: `pin_pu[i]` is 1 exactly when pullup bit i is 1 and `pin_oe[i]` is 0. It is never active on a driving pin.
- R8: A reset pulse leaves the data latch unchanged. `pin_out` and a later read with all direction bits at 1 return the value written before the reset.
- R9: A change on `pin_in` shows in reads and on `ser_rx` after the second rising clock edge following the change, and not after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| ser_en | input | 1 | Hands pins 0 and 1 to the serial peripheral |
| ser_tx | input | 1 | Transmit data from the peripheral |
| ser_rx | output | 1 | Receive data to the peripheral |
| pin_in | input | 6 | Raw pin levels |
| pin_oe | output | 6 | Per-pin driver enable |
| pin_out | output | 6 | Per-pin driven value |
| pin_pu | output | 6 | Per-pin pullup enable |

## Verification
The bench builds the port with its defaults: six pins, an 8-bit bus, transmit on pin 0, receive on pin 1 and two synchronizer stages. With these values the two unimplemented read bits can be observed, and both shared pins can be placed in every mix of direction bit and serial enable. Two stages also make the one-edge and two-edge latency points separately visible. A table of direction, latch, pullup, pin and serial patterns covers the ownership and read-mux cases. Directed steps cover the reset values, the latch that holds through reset, writes with the strobe low, and the synchronizer timing.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned BUS_W = 8;

  // Per-bit choice between output latch and sampled pin for a data read.
  function automatic logic [BUS_W-1:0] data_view(
    input logic [BUS_W-1:0] dir,
    input logic [BUS_W-1:0] lat,
    input logic [BUS_W-1:0] pin
  );
    return (dir & lat) | (~dir & pin);
  endfunction

  // A pullup is only offered to a pin that is not being driven.
  function automatic logic [BUS_W-1:0] pull_gate(
    input logic [BUS_W-1:0] pue,
    input logic [BUS_W-1:0] oe
  );
    return pue & ~oe;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_raw,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= d_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];

  // Latency check: only for the two-stage build, after two clean cycles.
  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] warm_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      end
      a_r9_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (d_sync == $past(d_raw, 2)));
    end
  endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [WIDTH-1:0]  wbits,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pue_q,
  output logic [DATA_W-1:0] rdata
);

  logic wr_lat, wr_dir, wr_pue;
  assign wr_lat = wr_en && (reg_sel_e'(addr) == SEL_DATA);
  assign wr_dir = wr_en && (reg_sel_e'(addr) == SEL_DIR);
  assign wr_pue = wr_en && (reg_sel_e'(addr) == SEL_PULL);

  // Output latch: deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (wr_lat) lat_q <= wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      pue_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wbits;
      if (wr_pue) pue_q <= wbits;
    end
  end

  logic [BUS_W-1:0] view_w;
  assign view_w = data_view(BUS_W'(dir_q), BUS_W'(lat_q), BUS_W'(pin_sync));

  always_comb begin
    rdata = '0;
    unique case (reg_sel_e'(addr))
      SEL_DATA: rdata[WIDTH-1:0] = view_w[WIDTH-1:0];
      SEL_DIR:  rdata[WIDTH-1:0] = dir_q;
      SEL_PULL: rdata[WIDTH-1:0] = pue_q;
      default:  rdata = '0;
    endcase
  end

  a_r2_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lat |=> $stable(lat_q));
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wbits)));
  a_r2_pue_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pue |=> (pue_q == $past(wbits)));

endmodule

// File: rtl/gpio_pin_route.sv
module gpio_pin_route
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned TX_PIN = 0,
  parameter int unsigned RX_PIN = 1
) (
  input  logic             ser_en,
  input  logic             ser_tx,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pue_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pu,
  output logic             ser_rx
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (i == TX_PIN) begin : g_tx
        assign pin_oe[i]  = ser_en ? 1'b1 : dir_q[i];
        assign pin_out[i] = ser_en ? ser_tx : lat_q[i];
      end else if (i == RX_PIN) begin : g_rx
        assign pin_oe[i]  = ser_en ? 1'b0 : dir_q[i];
        assign pin_out[i] = lat_q[i];
      end else begin : g_gp
        assign pin_oe[i]  = dir_q[i];
        assign pin_out[i] = lat_q[i];
      end
    end
  endgenerate

  logic [BUS_W-1:0] pu_w;
  assign pu_w   = pull_gate(BUS_W'(pue_q), BUS_W'(pin_oe));
  assign pin_pu = pu_w[WIDTH-1:0];

  assign ser_rx = ser_en ? pin_sync[RX_PIN] : 1'b1;

endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TX_PIN = 0,
  parameter int unsigned RX_PIN = 1,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ser_en,
  input  logic              ser_tx,
  output logic              ser_rx,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_pu
);

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] lat_q, dir_q, pue_q;
  logic             unused_hi;

  assign unused_hi = ^wdata[DATA_W-1:NPINS];

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_raw  (pin_in),
    .d_sync (pin_sync)
  );

  gpio_port_regs #(.WIDTH(NPINS), .DATA_W(DATA_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wbits    (wdata[NPINS-1:0]),
    .pin_sync (pin_sync),
    .lat_q    (lat_q),
    .dir_q    (dir_q),
    .pue_q    (pue_q),
    .rdata    (rdata)
  );

  gpio_pin_route #(.WIDTH(NPINS), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) i_route (
    .ser_en   (ser_en),
    .ser_tx   (ser_tx),
    .lat_q    (lat_q),
    .dir_q    (dir_q),
    .pue_q    (pue_q),
    .pin_sync (pin_sync),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out),
    .pin_pu   (pin_pu),
    .ser_rx   (ser_rx)
  );

  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NPINS] == '0);
  a_r4_tx_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> (pin_oe[TX_PIN] && (pin_out[TX_PIN] == ser_tx)));
  a_r4_rx_owned: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |-> !pin_oe[RX_PIN]);
  a_r3_dir_rules: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> (pin_oe == dir_q));
  a_r7_no_pull_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);
  a_r5_rx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> ser_rx);

endmodule

// File: tb/test_gpio_shared_port.sv
`timescale 1ns/1ps
module test_gpio_shared_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ser_en = 1'b0;
  logic       ser_tx = 1'b0;
  logic       ser_rx;
  logic [5:0] pin_in = 6'd0;
  logic [5:0] pin_oe, pin_out, pin_pu;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_shared_port i_gpio_shared_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ser_en(ser_en), .ser_tx(ser_tx), .ser_rx(ser_rx),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  typedef struct packed {
    logic       se;
    logic       tx;
    logic [5:0] dir;
    logic [5:0] lat;
    logic [5:0] pue;
    logic [5:0] pin;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 6'h00, 6'h00, 6'h3F, 6'h2A},
    '{1'b0, 1'b0, 6'h3F, 6'h15, 6'h3F, 6'h00},
    '{1'b0, 1'b1, 6'h0F, 6'h33, 6'h0C, 6'h3C},
    '{1'b1, 1'b1, 6'h00, 6'h3A, 6'h3F, 6'h15},
    '{1'b1, 1'b0, 6'h3F, 6'h0E, 6'h3F, 6'h2D},
    '{1'b1, 1'b1, 6'h02, 6'h01, 6'h03, 6'h02},
    '{1'b0, 1'b1, 6'h03, 6'h03, 6'h03, 6'h00},
    '{1'b1, 1'b0, 6'h3C, 6'h2C, 6'h3F, 6'h3F}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // Bench-side restatement of the pin rules, written per pin.
  function automatic logic [5:0] want_oe(input vec_t v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) begin
      if (v.se && i == 0)      r[i] = 1'b1;
      else if (v.se && i == 1) r[i] = 1'b0;
      else                     r[i] = v.dir[i];
    end
    return r;
  endfunction

  function automatic logic [5:0] want_read(input vec_t v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v.dir[i] ? v.lat[i] : v.pin[i];
    return r;
  endfunction

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic [5:0] e_oe, e_out;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    rd(2'd1, r); chk("R2 dir reset", r, 8'h00);
    rd(2'd2, r); chk("R2 pull reset", r, 8'h00);
    chk("R2 oe reset", {2'b0, pin_oe}, 8'h00);
    chk("R2 pu reset", {2'b0, pin_pu}, 8'h00);
    // R1: unused address and upper bits
    rd(2'd3, r); chk("R1 addr3 zero", r, 8'h00);
    wr(2'd1, 8'hFF);
    rd(2'd1, r); chk("R1 dir upper bits", r, 8'h3F);
    wr(2'd2, 8'hC5);
    rd(2'd2, r); chk("R1 pull upper bits", r, 8'h05);
    // R2: strobe low changes nothing
    @(negedge clk); addr = 2'd1; wdata = 8'h00; wr_en = 1'b0;
    @(negedge clk);
    rd(2'd1, r); chk("R2 no write without strobe", r, 8'h3F);

    // Table walk: R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      wr(2'd1, {2'b0, VECS[k].dir});
      wr(2'd0, {2'b0, VECS[k].lat});
      wr(2'd2, {2'b0, VECS[k].pue});
      @(negedge clk);
      ser_en = VECS[k].se; ser_tx = VECS[k].tx; pin_in = VECS[k].pin;
      repeat (3) @(negedge clk);
      e_oe  = want_oe(VECS[k]);
      e_out = VECS[k].lat;
      if (VECS[k].se) e_out[0] = VECS[k].tx;
      rd(2'd0, r); chk($sformatf("R6 read vec%0d", k), r, {2'b0, want_read(VECS[k])});
      chk($sformatf("R3/R4 oe vec%0d", k), {2'b0, pin_oe}, {2'b0, e_oe});
      chk($sformatf("R3/R4 out vec%0d", k), {2'b0, pin_out}, {2'b0, e_out});
      chk($sformatf("R7 pu vec%0d", k), {2'b0, pin_pu}, {2'b0, VECS[k].pue & ~e_oe});
      chk($sformatf("R5 rx vec%0d", k), {7'b0, ser_rx},
          {7'b0, VECS[k].se ? VECS[k].pin[1] : 1'b1});
    end

    // R8: latch survives reset
    ser_en = 1'b0;
    wr(2'd0, 8'h2D);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 pin_out after reset", {2'b0, pin_out}, 8'h2D);
    wr(2'd1, 8'h3F);
    rd(2'd0, r); chk("R8 latch read after reset", r, 8'h2D);

    // R9: two-edge synchronizer latency, seen on read and ser_rx
    wr(2'd1, 8'h00);
    ser_en = 1'b1;
    pin_in = 6'h00;
    repeat (3) @(negedge clk);
    pin_in = 6'h23;
    @(negedge clk);
    rd(2'd0, r); chk("R9 one edge: still old", r, 8'h00);
    chk("R9 one edge: rx old", {7'b0, ser_rx}, 8'h00);
    @(negedge clk);
    rd(2'd0, r); chk("R9 two edges: new", r, 8'h23);
    chk("R9 two edges: rx new", {7'b0, ser_rx}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule